// File: doc/BRIEF.md
# In-Place Vector Accumulate Engine

This block adds one vector of 32-bit words into another, in place, in global memory. A control block gives it two 64-bit base addresses (source vector and accumulator vector), an element count and a start pulse. The engine then works through the vectors in chunks. For each chunk it reads the source words, reads the accumulator words at the same positions, and writes their sums back over the accumulator words. It uses a single AXI4 memory-mapped master for all of this traffic. When the final write response has arrived it pulses `done` and returns to `idle`.

Every chunk is sized so that neither its source range nor its accumulator range crosses a 4 KB page. A chunk is also never longer than the burst limit or the work left. All bursts are full-width incrementing bursts. Each chunk is staged in a small local buffer, so a write to any accumulator word always comes after that word has been read.

All five bus channels use valid/ready. Once the engine raises a valid on an address or write-data channel, it keeps the payload fixed until the slave gives ready. The engine holds `rready` high only while it is collecting read beats, and `bready` high only while it waits for a write response. The slave may stall any channel for any number of cycles. `start`, `done` and `idle` are plain level and pulse signals with no handshake.

Top module: `vec_accum_engine`

## Requirements
- R1: After a run of N elements, accumulator word i (at base_b + 4*i, for i < N) holds the sum of its old value and source word i, modulo 2^32. No word outside these N positions is written, and exactly N write beats are issued.
- R2: In each chunk the source burst is read first, then the accumulator burst, and only then is the write burst to the same accumulator addresses issued. So every run issues exactly twice as many read bursts as write bursts, and no source word is changed.
- R3: The read and write addresses are 64 bits wide and run through the full 64-bit range of the base addresses, advancing 4 bytes per element.
- R4: Every AR and AW request uses burst type INCR (encoding 2'b01) and a beat size of 4 bytes (size code 3'b010). Every write beat has all four strobe bits set.
- R5: A burst carries 1 to 16 beats (length field 0 to 15) and never crosses a 4 KB address boundary. A chunk length is the smallest of 16, the elements remaining, and the words left before the next 4 KB boundary on each of the two vectors. For example, 40 elements with the source at page offset 0xFF8 and the accumulator at page offset 0xFF0 give five write bursts: 2, 2, 16, 16 and 4 beats.
- R6: `done` is a one-cycle pulse. It comes two cycles after the write-response handshake of the final burst, once every issued write burst has received its response.
- R7: `idle` is high after reset and from the cycle after `done` onward. It is low from the cycle after an accepted `start` until `done`, and is never high together with `done`. A `start` that arrives while the engine is busy is ignored.
- R8: An element count of zero issues no bus requests. For such a run, `done` is high in the second cycle after the `start` cycle.
- R9: Once AR, AW or W valid is raised, it stays high with the address, length, data and last flag unchanged until the matching ready is seen.
- R10: A run of 4096 elements completes with correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| elem_count | input | CNT_W | Number of 32-bit elements to process |
| base_a | input | ADDR_W | Byte address of the source vector |
| base_b | input | ADDR_W | Byte address of the accumulator vector (read and overwritten) |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | High when no run is in progress |
| m_araddr | output | ADDR_W | Read burst start address |
| m_arlen | output | 8 | Read burst beats minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read request valid |
| m_arready | input | 1 | Read request accepted |
| m_rdata | input | DATA_W | Read beat data |
| m_rlast | input | 1 | Final beat of a read burst |
| m_rvalid | input | 1 | Read beat valid |
| m_rready | output | 1 | Engine accepts read beat |
| m_awaddr | output | ADDR_W | Write burst start address |
| m_awlen | output | 8 | Write burst beats minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write request valid |
| m_awready | input | 1 | Write request accepted |
| m_wdata | output | DATA_W | Write beat data (sum) |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Final beat of a write burst |
| m_wvalid | output | 1 | Write beat valid |
| m_wready | input | 1 | Write beat accepted |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Engine accepts write response |

## Verification
The embedded properties assume a slave that follows the protocol. It returns exactly length-plus-one read beats per request, raises `rlast` only on the final one, and sends one write response per write burst, only after that burst's last beat. They also assume that both base addresses are word aligned. The bench's memory model is written to these rules: it serves one read burst at a time, counts down the beats it owes, and sends a response only after `wlast`. Its ready and valid timing follows a free-running LFSR, so stalls land on every channel. Every base address the bench uses is word aligned, with nonzero upper address bits.

// File: rtl/vae_pkg.sv
package vae_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PLAN,
    S_RD_A_REQ,
    S_RD_A_DAT,
    S_RD_B_REQ,
    S_RD_B_DAT,
    S_WR_REQ,
    S_WR_DAT,
    S_WR_RSP,
    S_FINISH
  } vae_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam int PAGE_OFF_W = 12;

endpackage

// File: rtl/vae_burst_planner.sv
module vae_burst_planner #(
  parameter int CNT_W      = 32,
  parameter int MAX_BEATS  = 16,
  parameter int BYTES      = 4,
  parameter int PAGE_OFF_W = 12,
  parameter int LEN_W      = $clog2(MAX_BEATS) + 1
) (
  input  logic [1:0][PAGE_OFF_W-1:0] page_off,
  input  logic [CNT_W-1:0]           remaining,
  output logic [LEN_W-1:0]           beats
);

  localparam int SHIFT  = $clog2(BYTES);
  localparam int ROOM_W = PAGE_OFF_W + 1;

  logic [ROOM_W-1:0] room [2];
  logic [CNT_W-1:0]  lim;

  // words left before the next page boundary, one per vector
  generate
    for (genvar k = 0; k < 2; k++) begin : g_room
      assign room[k] = ((ROOM_W'(1) << PAGE_OFF_W) - ROOM_W'(page_off[k])) >> SHIFT;
    end
  endgenerate

  always_comb begin
    lim = CNT_W'(MAX_BEATS);
    if (remaining < lim) lim = remaining;
    for (int k = 0; k < 2; k++) begin
      if (CNT_W'(room[k]) < lim) lim = CNT_W'(room[k]);
    end
    beats = LEN_W'(lim);
  end

endmodule

// File: rtl/vae_chunk_buf.sv
module vae_chunk_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  logic [DATA_W-1:0] rd_word [2];

  // bank 0 stages source words, bank 1 stages accumulator words
  generate
    for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [DATA_W-1:0] store [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_en && (wr_bank == 1'(g))) store[wr_idx] <= wr_data;
      end
      assign rd_word[g] = store[rd_idx];
    end
  endgenerate

  assign rd_a = rd_word[0];
  assign rd_b = rd_word[1];

endmodule

// File: rtl/vec_accum_engine.sv
module vec_accum_engine
  import vae_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int MAX_BEATS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    elem_count,
  input  logic [ADDR_W-1:0]   base_a,
  input  logic [ADDR_W-1:0]   base_b,
  output logic                done,
  output logic                idle,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic                m_bvalid,
  output logic                m_bready
);

  localparam int BYTES     = DATA_W / 8;
  localparam int SIZE_CODE = $clog2(BYTES);
  localparam int LEN_W     = $clog2(MAX_BEATS) + 1;
  localparam int IDX_W     = $clog2(MAX_BEATS);
  localparam int SPAN_W    = PAGE_OFF_W + 2;

  vae_state_e         state;
  logic [CNT_W-1:0]   rem;
  logic [ADDR_W-1:0]  addr_a, addr_b;
  logic [LEN_W-1:0]   len_q, beat, plan_beats;
  logic [DATA_W-1:0]  stage_a, stage_b;
  logic               last_beat;

  // ---------------- chunk sizing ----------------
  vae_burst_planner #(
    .CNT_W(CNT_W), .MAX_BEATS(MAX_BEATS), .BYTES(BYTES),
    .PAGE_OFF_W(PAGE_OFF_W), .LEN_W(LEN_W)
  ) planner_i (
    .page_off  ({addr_b[PAGE_OFF_W-1:0], addr_a[PAGE_OFF_W-1:0]}),
    .remaining (rem),
    .beats     (plan_beats)
  );

  // ---------------- staging buffer ----------------
  vae_chunk_buf #(.DATA_W(DATA_W), .DEPTH(MAX_BEATS), .IDX_W(IDX_W)) buf_i (
    .clk     (clk),
    .wr_en   (m_rvalid && m_rready),
    .wr_bank (state == S_RD_B_DAT),
    .wr_idx  (beat[IDX_W-1:0]),
    .wr_data (m_rdata),
    .rd_idx  (beat[IDX_W-1:0]),
    .rd_a    (stage_a),
    .rd_b    (stage_b)
  );

  assign last_beat = (beat == len_q - LEN_W'(1));

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rem    <= '0;
      addr_a <= '0;
      addr_b <= '0;
      len_q  <= '0;
      beat   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          rem    <= elem_count;
          addr_a <= base_a;
          addr_b <= base_b;
          state  <= S_PLAN;
        end
        S_PLAN: begin
          if (rem == '0) state <= S_FINISH;
          else begin
            len_q <= plan_beats;
            state <= S_RD_A_REQ;
          end
        end
        S_RD_A_REQ: if (m_arready) begin
          beat  <= '0;
          state <= S_RD_A_DAT;
        end
        S_RD_A_DAT: if (m_rvalid) begin
          beat <= beat + LEN_W'(1);
          if (m_rlast) state <= S_RD_B_REQ;
        end
        S_RD_B_REQ: if (m_arready) begin
          beat  <= '0;
          state <= S_RD_B_DAT;
        end
        S_RD_B_DAT: if (m_rvalid) begin
          beat <= beat + LEN_W'(1);
          if (m_rlast) state <= S_WR_REQ;
        end
        S_WR_REQ: if (m_awready) begin
          beat  <= '0;
          state <= S_WR_DAT;
        end
        S_WR_DAT: if (m_wready) begin
          beat <= beat + LEN_W'(1);
          if (last_beat) state <= S_WR_RSP;
        end
        S_WR_RSP: if (m_bvalid) begin
          rem    <= rem - CNT_W'(len_q);
          addr_a <= addr_a + (ADDR_W'(len_q) << SIZE_CODE);
          addr_b <= addr_b + (ADDR_W'(len_q) << SIZE_CODE);
          state  <= S_PLAN;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // ---------------- bus outputs ----------------
  assign m_arvalid = (state == S_RD_A_REQ) || (state == S_RD_B_REQ);
  assign m_araddr  = (state == S_RD_B_REQ) ? addr_b : addr_a;
  assign m_arlen   = 8'(len_q) - 8'd1;
  assign m_arsize  = 3'(SIZE_CODE);
  assign m_arburst = BURST_INCR;
  assign m_rready  = (state == S_RD_A_DAT) || (state == S_RD_B_DAT);

  assign m_awvalid = (state == S_WR_REQ);
  assign m_awaddr  = addr_b;
  assign m_awlen   = 8'(len_q) - 8'd1;
  assign m_awsize  = 3'(SIZE_CODE);
  assign m_awburst = BURST_INCR;

  assign m_wvalid  = (state == S_WR_DAT);
  assign m_wdata   = stage_a + stage_b;
  assign m_wstrb   = '1;
  assign m_wlast   = last_beat;
  assign m_bready  = (state == S_WR_RSP);

  assign done = (state == S_FINISH);
  assign idle = (state == S_IDLE);

  // ---------------- assertions ----------------
  assert_ar_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

  assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));

  assert_w_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));

  assert_ar_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (SPAN_W'(m_araddr[PAGE_OFF_W-1:0]) + (SPAN_W'(m_arlen) + SPAN_W'(1)) * SPAN_W'(BYTES))
                  <= (SPAN_W'(1) << PAGE_OFF_W));

  assert_aw_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (SPAN_W'(m_awaddr[PAGE_OFF_W-1:0]) + (SPAN_W'(m_awlen) + SPAN_W'(1)) * SPAN_W'(BYTES))
                  <= (SPAN_W'(1) << PAGE_OFF_W));

  assert_plan_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PLAN) && (rem != '0) |=> (len_q != '0) && (CNT_W'(len_q) <= rem)
                                         && (len_q <= LEN_W'(MAX_BEATS)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && idle);

  assert_done_idle_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && idle));

endmodule

// File: tb/vec_accum_engine_tb_top.sv
module vec_accum_engine_tb_top;

  localparam logic [63:0] HI = 64'hC0DE_0042_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] elem_count = '0;
  logic [63:0] base_a = '0, base_b = '0;
  logic        done, idle;
  logic [63:0] m_araddr, m_awaddr;
  logic [7:0]  m_arlen, m_awlen;
  logic [2:0]  m_arsize, m_awsize;
  logic [1:0]  m_arburst, m_awburst;
  logic        m_arvalid, m_rready, m_awvalid, m_wlast, m_wvalid, m_bready;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_arready = 0, m_rlast = 0, m_rvalid = 0, m_awready = 0, m_wready = 0, m_bvalid = 0;
  logic [31:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  vec_accum_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
    .base_a(base_a), .base_b(base_b), .done(done), .idle(idle),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(m_wready), .m_bvalid(m_bvalid), .m_bready(m_bready)
  );

  // ---------------- memory slave model ----------------
  logic [31:0] mem [16384];
  logic        pl_en = 1'b0;
  logic [13:0] pl_ia = '0, pl_ib = '0;
  logic [31:0] pl_da = '0, pl_db = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        rd_active = 0, wr_active = 0;
  logic [63:0] rd_addr = '0, wr_addr = '0;
  logic [7:0]  rd_left = '0, wr_left = '0;
  logic        ar_wait = 0, aw_wait = 0, w_wait = 0;
  logic [63:0] ar_h_addr = '0, aw_h_addr = '0;
  logic [7:0]  ar_h_len = '0, aw_h_len = '0;
  logic [31:0] w_h_data = '0;
  logic        w_h_last = 0;
  int ar_cnt = 0, aw_cnt = 0, w_beats = 0, b_cnt = 0, proto_err = 0;

  task automatic chk_req(input logic [63:0] a, input logic [7:0] l, input logic [2:0] s,
                         input logic [1:0] b, input string ch);
    if (a[63:16] != HI[63:16] || a[1:0] != 2'b00) begin
      proto_err++; $display("  model: %s address %0h outside window (R3)", ch, a);
    end
    if (b != 2'b01 || s != 3'b010) begin
      proto_err++; $display("  model: %s burst=%0d size=%0d (R4)", ch, b, s);
    end
    if (l > 8'd15 || ({20'd0, a[11:0]} + ({24'd0, l} + 32'd1) * 32'd4) > 32'd4096) begin
      proto_err++; $display("  model: %s len=%0d at %0h breaks limit (R5)", ch, l, a);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arready <= 0; m_rvalid <= 0; m_rlast <= 0; m_awready <= 0;
      m_wready <= 0; m_bvalid <= 0; rd_active <= 0; wr_active <= 0;
      ar_wait <= 0; aw_wait <= 0; w_wait <= 0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (pl_en) begin mem[pl_ia] <= pl_da; mem[pl_ib] <= pl_db; end
      // payload hold checks (R9)
      if (ar_wait && !(m_arvalid && m_araddr == ar_h_addr && m_arlen == ar_h_len)) begin
        proto_err++; $display("  model: AR payload dropped while stalled (R9)");
      end
      if (aw_wait && !(m_awvalid && m_awaddr == aw_h_addr && m_awlen == aw_h_len)) begin
        proto_err++; $display("  model: AW payload dropped while stalled (R9)");
      end
      if (w_wait && !(m_wvalid && m_wdata == w_h_data && m_wlast == w_h_last)) begin
        proto_err++; $display("  model: W payload dropped while stalled (R9)");
      end
      ar_wait <= m_arvalid && !m_arready; ar_h_addr <= m_araddr; ar_h_len <= m_arlen;
      aw_wait <= m_awvalid && !m_awready; aw_h_addr <= m_awaddr; aw_h_len <= m_awlen;
      w_wait  <= m_wvalid && !m_wready;   w_h_data  <= m_wdata;  w_h_last <= m_wlast;
      // read address
      m_arready <= !rd_active && !(m_arvalid && m_arready) && lfsr[0];
      if (m_arvalid && m_arready && !rd_active) begin
        chk_req(m_araddr, m_arlen, m_arsize, m_arburst, "AR");
        rd_active <= 1; rd_addr <= m_araddr; rd_left <= m_arlen; ar_cnt++;
      end
      // read data
      if (m_rvalid && m_rready) begin
        m_rvalid <= 0;
        if (m_rlast) rd_active <= 0;
      end else if (rd_active && !m_rvalid && lfsr[1]) begin
        m_rvalid <= 1; m_rdata <= mem[rd_addr[15:2]]; m_rlast <= (rd_left == 0);
        rd_addr <= rd_addr + 64'd4; rd_left <= rd_left - 8'd1;
      end
      // write response
      if (m_bvalid && m_bready) begin m_bvalid <= 0; b_cnt++; end
      // write address
      m_awready <= !wr_active && !(m_awvalid && m_awready) && lfsr[2];
      if (m_awvalid && m_awready && !wr_active) begin
        chk_req(m_awaddr, m_awlen, m_awsize, m_awburst, "AW");
        wr_active <= 1; wr_addr <= m_awaddr; wr_left <= m_awlen; aw_cnt++;
      end
      // write data
      m_wready <= lfsr[3];
      if (m_wvalid && m_wready) begin
        if (!wr_active) begin proto_err++; $display("  model: W beat without AW (R2)"); end
        if (m_wstrb != 4'hF) begin proto_err++; $display("  model: strobe %0h (R4)", m_wstrb); end
        if (m_wlast != (wr_left == 0)) begin proto_err++; $display("  model: wlast misplaced (R5)"); end
        mem[wr_addr[15:2]] <= m_wdata;
        wr_addr <= wr_addr + 64'd4; wr_left <= wr_left - 8'd1; w_beats++;
        if (m_wlast) begin wr_active <= 0; m_bvalid <= 1; end
      end
    end
  end

  // ---------------- bench bookkeeping ----------------
  int checks = 0, failures = 0;
  bit wd_hit = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] a_pat(int i, int seed);
    return 32'hFFFF_FFF0 + 32'(seed) * 32'h1000_0001 + 32'(i) * 32'h0001_0003;
  endfunction
  function automatic logic [31:0] b_pat(int i, int seed);
    return (32'h8000_0000 + 32'(i) * 32'h0000_0101) ^ 32'(seed);
  endfunction

  task automatic preload(int n, logic [15:0] a_off, logic [15:0] b_off, int seed);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      pl_en = 1;
      pl_ia = 14'(a_off[15:2] + 14'(i)); pl_da = a_pat(i, seed);
      pl_ib = 14'(b_off[15:2] + 14'(i)); pl_db = b_pat(i, seed);
    end
    @(negedge clk);
    pl_en = 0;
    @(negedge clk);
  endtask

  // one complete run; exp_aw < 0 skips the burst-count check
  task automatic run_case(input string name, input int n, input logic [15:0] a_off,
                          input logic [15:0] b_off, input int seed, input int exp_aw,
                          input bit poke);
    int ar0, aw0, w0, b0, pe0, cyc, bad;
    $display("-- %s (n=%0d)", name, n);
    preload(n, a_off, b_off, seed);
    ar0 = ar_cnt; aw0 = aw_cnt; w0 = w_beats; b0 = b_cnt; pe0 = proto_err;
    elem_count = 32'(n); base_a = HI | 64'(a_off); base_b = HI | 64'(b_off);
    start = 1;
    @(negedge clk);
    start = 0;
    check(!idle && !done, "R7", "idle low once started", {62'd0, idle, done}, 64'd0);
    if (poke) begin
      repeat (10) @(negedge clk);
      elem_count = 32'd1000; base_a = HI | 64'h0000; base_b = HI | 64'hF000;
      start = 1;
      @(negedge clk);
      start = 0;
      elem_count = 32'(n); base_a = HI | 64'(a_off); base_b = HI | 64'(b_off);
    end
    cyc = 0;
    while (!done && cyc < 120000) begin @(negedge clk); cyc++; end
    check(done == 1'b1, "R6", "done reached", {63'd0, done}, 64'd1);
    check(b_cnt - b0 == aw_cnt - aw0, "R6", "responses before done", 64'(b_cnt - b0), 64'(aw_cnt - aw0));
    check(!idle, "R7", "idle low during done", {63'd0, idle}, 64'd0);
    @(negedge clk);
    check(!done && idle, "R6", "done one cycle then idle", {62'd0, done, idle}, 64'd1);
    check(w_beats - w0 == n, "R1", "write beat total", 64'(w_beats - w0), 64'(n));
    check(ar_cnt - ar0 == 2 * (aw_cnt - aw0), "R2", "two reads per write burst",
          64'(ar_cnt - ar0), 64'(2 * (aw_cnt - aw0)));
    if (exp_aw >= 0)
      check(aw_cnt - aw0 == exp_aw, "R5", "write burst count", 64'(aw_cnt - aw0), 64'(exp_aw));
    check(proto_err == pe0, "R4", "request fields, page limit, hold (R3 R5 R9)",
          64'(proto_err - pe0), 64'd0);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] expv, got;
      expv = a_pat(i, seed) + b_pat(i, seed);
      got  = mem[14'(b_off[15:2] + 14'(i))];
      if (got !== expv) begin
        if (bad == 0) check(0, (n == 4096) ? "R10" : "R1", "sum word", {32'd0, got}, {32'd0, expv});
        bad++;
      end
    end
    if (bad == 0) check(1, "R1", "sum words", 0, 0);
    bad = 0;
    for (int i = 0; i < n; i++)
      if (mem[14'(a_off[15:2] + 14'(i))] !== a_pat(i, seed)) bad++;
    check(bad == 0, "R2", "source words unchanged", 64'(bad), 64'd0);
    check(mem[14'(b_off[15:2] + 14'(n))] === b_pat(n, seed), "R1", "word past end untouched",
          {32'd0, mem[14'(b_off[15:2] + 14'(n))]}, {32'd0, b_pat(n, seed)});
  endtask

  task automatic test_reset();
    $display("-- reset state");
    check(idle && !done, "R7", "idle after reset", {62'd0, idle, done}, 64'd2);
    check(!m_arvalid && !m_awvalid && !m_wvalid, "R9", "no requests after reset",
          {61'd0, m_arvalid, m_awvalid, m_wvalid}, 64'd0);
  endtask

  task automatic test_zero();
    int ar0, aw0;
    $display("-- zero count");
    ar0 = ar_cnt; aw0 = aw_cnt;
    elem_count = 0; base_a = HI; base_b = HI | 64'h8000;
    start = 1;
    @(negedge clk);
    start = 0;
    check(!done, "R8", "done not yet one cycle after start", {63'd0, done}, 64'd0);
    @(negedge clk);
    check(done, "R8", "done two cycles after start", {63'd0, done}, 64'd1);
    @(negedge clk);
    check(idle && !done, "R7", "idle after zero run", {62'd0, idle, done}, 64'd2);
    check(ar_cnt == ar0 && aw_cnt == aw0, "R8", "no bus requests",
          64'(ar_cnt - ar0 + aw_cnt - aw0), 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        test_reset();
        run_case("short aligned run", 5, 16'h0100, 16'h4000, 3, 1, 0);
        run_case("page crossing with wrap", 40, 16'h0FF8, 16'h9FF0, 7, 5, 0);
        test_zero();
        run_case("start while busy ignored (R7)", 20, 16'h2000, 16'h6000, 11, 2, 1);
        run_case("full 4096 element run", 4096, 16'h0000, 16'h8000, 5, 256, 0);
      end
      begin
        repeat (190000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    if (wd_hit) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule